// File: doc/BRIEF.md
# Reset Pin Stretch Controller

This block owns the shared active-low reset line of a microcontroller system. The line is open-drain: the block pulls it low through `pin_drive_en` and reads the wire level back on `rst_pin_in`. Reset requests come from the power-on indication, from any number of internal sources, and from outside agents that pull the wire low. The block stretches every reset to a fixed length. It then lets go of the wire and checks whether anything else is still holding it low. It keeps retrying until the wire reads high. Only then does it start exception processing.

The controller has six states. DRIVE pulls the wire low and counts a stretch of `STRETCH_CYCLES` clocks. The count starts only once no internal request is active and, after power-on, only once the PLL has reported lock. RELEASE leaves the wire undriven for `RELEASE_CYCLES` clocks. TEST samples the synchronized wire level for one cycle. DONE emits the start pulse for one cycle. IDLE is normal operation. WAIT_BUS is entered when an outside agent pulls the wire low; it postpones the stretch until the bus is idle or the bus monitor times out, so a write in flight is not cut short.

The transitions are:
- IDLE→DRIVE on an internal request.
- IDLE→WAIT_BUS on a low synchronized wire.
- WAIT_BUS→DRIVE on bus idle, bus timeout or an internal request.
- DRIVE→RELEASE at the end of the count.
- RELEASE→TEST at the end of the window.
- TEST→DONE on a high wire.
- TEST→DRIVE on a low wire.
- RELEASE/TEST→DRIVE on an internal request.
- DONE→IDLE always.
- Power-on forces DRIVE asynchronously.

Top module: `reset_stretch_ctrl`

## Requirements
- R1: While `por_active` is high, `pin_drive_en` and `sys_rst` are 1 and `rst_done` is 0. These values appear without waiting for a clock edge.
- R2: After power-on, `pin_drive_en` stays 1 while `pll_locked` is 0. Once lock is seen, it stays 1 for exactly 512 more sampled cycles.
- R3: A drive period with no active source asserts `pin_drive_en` for exactly `STRETCH_CYCLES` (512) cycles.
- R4: Each drive period is followed by `RELEASE_CYCLES` (10) undriven cycles and then one undriven TEST cycle, which is 11 cycles with `pin_drive_en`=0.
- R5: If the synchronized wire reads 0 in TEST, a new drive period starts. The loop repeats until the wire reads 1 in TEST.
- R6: The wire level passes through a two-flop synchronizer. A low level in IDLE leads to WAIT_BUS, where `sys_rst`=1 and `pin_drive_en`=0. The block stays in WAIT_BUS until `bus_idle` or `bus_timeout` is 1, then enters DRIVE.
- R7: An internal request in IDLE enters DRIVE directly, with no bus wait. While any request is active in DRIVE, the count is held at its reload value. Drive lasts 512 cycles counting the cycle in which the last request is sampled low. A request in RELEASE or TEST restarts DRIVE.
- R8: A high wire in TEST gives `rst_done`=1 for exactly one cycle (DONE), followed by IDLE.
- R9: `sys_rst` is 1 in every state except IDLE.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por_active | input | 1 | Power-on reset indication, active high, asynchronous |
| pll_locked | input | 1 | PLL lock flag |
| int_rst_req | input | N_INT | Internal reset requests, active high |
| rst_pin_in | input | 1 | Level read back from the reset wire (0 = asserted) |
| bus_idle | input | 1 | No bus cycle in progress |
| bus_timeout | input | 1 | Bus monitor timeout strobe |
| pin_drive_en | output | 1 | 1 pulls the reset wire low |
| sys_rst | output | 1 | System reset, active high |
| rst_done | output | 1 | One-cycle pulse that starts reset exception processing |

## Verification
The bench targets the off-by-one boundaries of the two intervals.

- Counting from the wrong reload value, or releasing the hold one cycle late, changes the 512 or 11 cycle counts measured at the pin.
- A controller that ignores the sampled wire in TEST would finish after the first release while an outside agent still holds the line low.
- A controller that skips the bus wait would pull the wire in the middle of a bus write.
- A block that counts through a power-on before PLL lock would release the system early.

A cycle-accurate behavioural model runs next to the design. It flags any cycle in which the drive, reset or done outputs differ from the model.

// File: rtl/rstc_pkg.sv
package rstc_pkg;
    typedef enum logic [2:0] {
        ST_IDLE     = 3'd0,
        ST_WAIT_BUS = 3'd1,
        ST_DRIVE    = 3'd2,
        ST_RELEASE  = 3'd3,
        ST_TEST     = 3'd4,
        ST_DONE     = 3'd5
    } rstc_state_e;
endpackage

// File: rtl/rstc_sync.sv
module rstc_sync #(
    parameter int   STAGES  = 2,
    parameter logic RST_VAL = 1'b0
) (
    input  logic clk,
    input  logic arst,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] chain;

    always_ff @(posedge clk or posedge arst) begin
        if (arst) chain[0] <= RST_VAL;
        else      chain[0] <= d;
    end

    generate
        for (genvar i = 1; i < STAGES; i++) begin : g_stage
            always_ff @(posedge clk or posedge arst) begin
                if (arst) chain[i] <= RST_VAL;
                else      chain[i] <= chain[i-1];
            end
        end
    endgenerate

    assign q = chain[STAGES-1];
endmodule

// File: rtl/rstc_timer.sv
module rstc_timer #(
    parameter int             W       = 9,
    parameter logic [W-1:0]   RST_VAL = '0
) (
    input  logic         clk,
    input  logic         arst,
    input  logic         load,
    input  logic [W-1:0] load_val,
    output logic [W-1:0] cnt,
    output logic         zero
);
    always_ff @(posedge clk or posedge arst) begin
        if (arst)            cnt <= RST_VAL;
        else if (load)       cnt <= load_val;
        else if (cnt != '0)  cnt <= cnt - 1'b1;
    end

    assign zero = (cnt == '0);
endmodule

// File: rtl/reset_stretch_ctrl.sv
module reset_stretch_ctrl
    import rstc_pkg::*;
#(
    parameter int STRETCH_CYCLES = 512,
    parameter int RELEASE_CYCLES = 10,
    parameter int N_INT          = 2,
    parameter int SYNC_STAGES    = 2
) (
    input  logic             clk,
    input  logic             por_active,
    input  logic             pll_locked,
    input  logic [N_INT-1:0] int_rst_req,
    input  logic             rst_pin_in,
    input  logic             bus_idle,
    input  logic             bus_timeout,
    output logic             pin_drive_en,
    output logic             sys_rst,
    output logic             rst_done
);
    localparam int MAX_IV = (STRETCH_CYCLES > RELEASE_CYCLES) ? STRETCH_CYCLES : RELEASE_CYCLES;
    localparam int CNT_W  = (MAX_IV > 2) ? $clog2(MAX_IV) : 1;
    localparam logic [CNT_W-1:0] STRETCH_LD = CNT_W'(STRETCH_CYCLES - 1);
    localparam logic [CNT_W-1:0] RELEASE_LD = CNT_W'(RELEASE_CYCLES - 1);

    rstc_state_e      state_q, state_d;
    logic             pin_sync;
    logic             int_any;
    logic             lock_wait;
    logic             tmr_load;
    logic [CNT_W-1:0] tmr_val;
    logic [CNT_W-1:0] tmr_cnt;
    logic             tmr_zero;

    assign int_any = |int_rst_req;

    // Wire level is asynchronous to clk: two-flop synchronizer (R6).
    rstc_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_pin_sync (
        .clk  (clk),
        .arst (por_active),
        .d    (rst_pin_in),
        .q    (pin_sync)
    );

    rstc_timer #(.W(CNT_W), .RST_VAL(STRETCH_LD)) u_timer (
        .clk      (clk),
        .arst     (por_active),
        .load     (tmr_load),
        .load_val (tmr_val),
        .cnt      (tmr_cnt),
        .zero     (tmr_zero)
    );

    // Power-on waits for the PLL before the stretch may count (R2).
    always_ff @(posedge clk or posedge por_active) begin
        if (por_active)      lock_wait <= 1'b1;
        else if (pll_locked) lock_wait <= 1'b0;
    end

    always_ff @(posedge clk or posedge por_active) begin
        if (por_active) state_q <= ST_DRIVE;
        else            state_q <= state_d;
    end

    always_comb begin
        state_d  = state_q;
        tmr_load = 1'b0;
        tmr_val  = STRETCH_LD;
        unique case (state_q)
            ST_IDLE: begin
                if (int_any) begin
                    state_d  = ST_DRIVE;
                    tmr_load = 1'b1;
                end else if (!pin_sync) begin
                    state_d = ST_WAIT_BUS;
                end
            end
            ST_WAIT_BUS: begin
                if (int_any || bus_idle || bus_timeout) begin
                    state_d  = ST_DRIVE;
                    tmr_load = 1'b1;
                end
            end
            ST_DRIVE: begin
                if (int_any || lock_wait) begin
                    tmr_load = 1'b1;
                end else if (tmr_zero) begin
                    state_d  = ST_RELEASE;
                    tmr_load = 1'b1;
                    tmr_val  = RELEASE_LD;
                end
            end
            ST_RELEASE: begin
                if (int_any) begin
                    state_d  = ST_DRIVE;
                    tmr_load = 1'b1;
                end else if (tmr_zero) begin
                    state_d = ST_TEST;
                end
            end
            ST_TEST: begin
                if (int_any || !pin_sync) begin
                    state_d  = ST_DRIVE;
                    tmr_load = 1'b1;
                end else begin
                    state_d = ST_DONE;
                end
            end
            ST_DONE: begin
                state_d = ST_IDLE;
            end
            default: begin
                state_d  = ST_DRIVE;
                tmr_load = 1'b1;
            end
        endcase
    end

    always_comb begin
        pin_drive_en = 1'b0;
        sys_rst      = 1'b1;
        rst_done     = 1'b0;
        unique case (state_q)
            ST_IDLE:     sys_rst      = 1'b0;
            ST_WAIT_BUS: ;
            ST_DRIVE:    pin_drive_en = 1'b1;
            ST_RELEASE:  ;
            ST_TEST:     ;
            ST_DONE:     rst_done     = 1'b1;
            default:     pin_drive_en = 1'b1;
        endcase
    end
endmodule

// File: rtl/rstc_checker.sv
module rstc_checker
    import rstc_pkg::*;
#(
    parameter int               CNT_W      = 9,
    parameter logic [CNT_W-1:0] STRETCH_LD = '1,
    parameter logic [CNT_W-1:0] RELEASE_LD = '0
) (
    input logic             clk,
    input logic             por_active,
    input logic             int_any,
    input logic             pin_sync,
    input logic             bus_idle,
    input logic             bus_timeout,
    input rstc_state_e      state,
    input logic [CNT_W-1:0] cnt,
    input logic             pin_drive_en,
    input logic             sys_rst,
    input logic             rst_done
);
    p_por_drive_r1: assert property (@(posedge clk)
        por_active |-> (pin_drive_en && sys_rst && !rst_done));

    p_release_entry_r4: assert property (@(posedge clk) disable iff (por_active)
        $fell(pin_drive_en) |-> (state == ST_RELEASE && cnt == RELEASE_LD));

    p_test_low_redrive_r5: assert property (@(posedge clk) disable iff (por_active)
        (state == ST_TEST && !pin_sync) |=> pin_drive_en);

    p_bus_wait_r6: assert property (@(posedge clk) disable iff (por_active)
        (state == ST_WAIT_BUS && !bus_idle && !bus_timeout && !int_any)
        |=> (state == ST_WAIT_BUS && !pin_drive_en && sys_rst));

    p_hold_reload_r7: assert property (@(posedge clk) disable iff (por_active)
        (state == ST_DRIVE && int_any) |=> (pin_drive_en && cnt == STRETCH_LD));

    p_done_single_r8: assert property (@(posedge clk) disable iff (por_active)
        rst_done |=> (!rst_done && !sys_rst));

    p_done_in_reset_r9: assert property (@(posedge clk) disable iff (por_active)
        rst_done |-> sys_rst);
endmodule

bind reset_stretch_ctrl rstc_checker #(
    .CNT_W      (CNT_W),
    .STRETCH_LD (STRETCH_LD),
    .RELEASE_LD (RELEASE_LD)
) u_chk (
    .clk          (clk),
    .por_active   (por_active),
    .int_any      (int_any),
    .pin_sync     (pin_sync),
    .bus_idle     (bus_idle),
    .bus_timeout  (bus_timeout),
    .state        (state_q),
    .cnt          (tmr_cnt),
    .pin_drive_en (pin_drive_en),
    .sys_rst      (sys_rst),
    .rst_done     (rst_done)
);

// File: tb/tb_reset_stretch_ctrl.sv
`timescale 1ns/1ps
module tb_reset_stretch_ctrl;
    localparam int STRETCH = 512;
    localparam int RELWIN  = 10;
    localparam int P_IDLE = 0, P_WAIT = 1, P_DRIVE = 2, P_REL = 3, P_TEST = 4, P_DONE = 5;

    logic       clk = 1'b0;
    logic       por_active = 1'b0;
    logic       pll_locked = 1'b0;
    logic [1:0] int_rst_req = 2'b00;
    logic       bus_idle = 1'b1;
    logic       bus_timeout = 1'b0;
    logic       ext_low = 1'b0;
    logic       rst_pin_in;
    logic       pin_drive_en, sys_rst, rst_done;

    int total = 0;
    int bad = 0;
    bit started = 0;

    always #2.5 clk = ~clk;

    assign rst_pin_in = !(pin_drive_en || ext_low);

    reset_stretch_ctrl #(.STRETCH_CYCLES(STRETCH), .RELEASE_CYCLES(RELWIN), .N_INT(2)) dut (
        .clk(clk), .por_active(por_active), .pll_locked(pll_locked),
        .int_rst_req(int_rst_req), .rst_pin_in(rst_pin_in),
        .bus_idle(bus_idle), .bus_timeout(bus_timeout),
        .pin_drive_en(pin_drive_en), .sys_rst(sys_rst), .rst_done(rst_done)
    );

    task automatic chk(input string req, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    // Behavioural reference: phase number, cycles left, lock wait, sync pipe.
    int m_ph = P_DRIVE;
    int m_left = STRETCH - 1;
    bit m_lw = 1, m_s1 = 0, m_s2 = 0;

    always @(posedge clk or posedge por_active) begin
        if (por_active) begin
            m_ph = P_DRIVE; m_left = STRETCH - 1; m_lw = 1; m_s1 = 0; m_s2 = 0;
        end else begin
            automatic int  ph = m_ph;
            automatic bit  seen = m_s2;
            automatic bit  req = |int_rst_req;
            automatic bit  lw = m_lw;
            automatic bit  wire_lvl = !((ph == P_DRIVE) || ext_low);
            m_lw = lw && !pll_locked;
            m_s2 = m_s1;
            m_s1 = wire_lvl;
            if (ph == P_IDLE) begin
                if (req) begin m_ph = P_DRIVE; m_left = STRETCH - 1; end
                else if (!seen) m_ph = P_WAIT;
            end else if (ph == P_WAIT) begin
                if (req || bus_idle || bus_timeout) begin m_ph = P_DRIVE; m_left = STRETCH - 1; end
            end else if (ph == P_DRIVE) begin
                if (req || lw) m_left = STRETCH - 1;
                else if (m_left == 0) begin m_ph = P_REL; m_left = RELWIN - 1; end
                else m_left--;
            end else if (ph == P_REL) begin
                if (req) begin m_ph = P_DRIVE; m_left = STRETCH - 1; end
                else if (m_left == 0) m_ph = P_TEST;
                else m_left--;
            end else if (ph == P_TEST) begin
                if (req || !seen) begin m_ph = P_DRIVE; m_left = STRETCH - 1; end
                else m_ph = P_DONE;
            end else begin
                m_ph = P_IDLE;
            end
        end
    end

    always @(negedge clk) begin
        if (started) begin
            chk("R3 drive vs model", int'(pin_drive_en), int'(m_ph == P_DRIVE));
            chk("R9 sys_rst vs model", int'(sys_rst), int'(m_ph != P_IDLE));
            chk("R8 done vs model", int'(rst_done), int'(m_ph == P_DONE));
        end
    end

    task automatic finish_run();
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        bad++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    task automatic wait_done();
        int guard = 0;
        while (!rst_done && guard < 5000) begin @(negedge clk); guard++; end
        @(negedge clk);
    endtask

    initial begin
        int n;
        int periods;
        bit prev;
        #1 por_active = 1'b1;
        started = 1;
        // R1: power-on state
        repeat (4) begin
            @(negedge clk);
            chk("R1 drive in por", int'(pin_drive_en), 1);
            chk("R1 sys_rst in por", int'(sys_rst), 1);
            chk("R1 no done in por", int'(rst_done), 0);
        end
        #1 por_active = 1'b0;
        // R2: no count without lock
        repeat (30) @(negedge clk);
        chk("R2 drive held before lock", int'(pin_drive_en), 1);
        #1 pll_locked = 1'b1;
        n = 0;
        @(negedge clk);
        while (pin_drive_en && n < 3000) begin n++; @(negedge clk); end
        chk("R2 cycles after lock", n, 512);
        n = 0;
        while (!rst_done && n < 100) begin n++; @(negedge clk); end
        chk("R4 undriven cycles before done", n, RELWIN + 1);
        @(negedge clk);
        chk("R8 done single cycle", int'(rst_done), 0);
        chk("R9 idle after done", int'(sys_rst), 0);

        // R7: internal request from IDLE, held count
        #1 int_rst_req = 2'b10;
        @(negedge clk);
        chk("R7 direct drive on internal", int'(pin_drive_en), 1);
        repeat (29) @(negedge clk);
        #1 int_rst_req = 2'b00;
        n = 0;
        @(negedge clk);
        while (pin_drive_en && n < 3000) begin n++; @(negedge clk); end
        chk("R7 drive incl negation cycle", n + 1, 512);
        wait_done();
        chk("R9 idle after internal", int'(sys_rst), 0);

        // R6 / R5: external hold with busy bus, retried
        bus_idle = 1'b0;
        #1 ext_low = 1'b1;
        repeat (20) @(negedge clk);
        chk("R6 waiting sys_rst", int'(sys_rst), 1);
        chk("R6 waiting no drive", int'(pin_drive_en), 0);
        #1 bus_timeout = 1'b1;
        @(negedge clk);
        #1 bus_timeout = 1'b0;
        chk("R6 drive after timeout", int'(pin_drive_en), 1);
        periods = 1; prev = 1;
        n = 0;
        while (!rst_done && n < 5000) begin
            @(negedge clk);
            n++;
            if (pin_drive_en && !prev) begin
                periods++;
                if (periods == 2) #1 ext_low = 1'b0;
            end
            prev = pin_drive_en;
        end
        chk("R5 drive periods", periods, 2);
        @(negedge clk);

        // R6 with idle bus, then R7 request in release window
        bus_idle = 1'b1;
        #1 ext_low = 1'b1;
        repeat (3) @(negedge clk);
        #1 ext_low = 1'b0;
        repeat (3) @(negedge clk);
        chk("R6 drive with idle bus", int'(pin_drive_en), 1);
        n = 0;
        while (pin_drive_en && n < 3000) begin n++; @(negedge clk); end
        repeat (3) @(negedge clk);
        #1 int_rst_req = 2'b01;
        @(negedge clk);
        chk("R7 restart from release", int'(pin_drive_en), 1);
        #1 int_rst_req = 2'b00;
        wait_done();

        // R1: asynchronous power-on from IDLE
        repeat (3) @(negedge clk);
        #1 por_active = 1'b1;
        #1;
        chk("R1 async drive", int'(pin_drive_en), 1);
        chk("R1 async sys_rst", int'(sys_rst), 1);
        @(negedge clk);
        #1 por_active = 1'b0;
        wait_done();
        chk("R8 completes after por", int'(sys_rst), 0);
        repeat (2) @(negedge clk);
        finish_run();
    end
endmodule